// File: doc/BRIEF.md
# Panel Scan Timing Generator

This block produces the horizontal and vertical scan timing for an active-matrix panel from a single pixel clock. A line is a run of pixel clocks split into four phases: sync, begin, data and end. A frame is a run of lines split into the same four phases. An optional hold-off of extra blanking lines follows the frame. From these counts the block derives the gate-driver clock, start pulse and output enable. It also derives a source latch enable and two chained source output-enable pulses. Every derived signal has its own offsets, widths, mode and polarity.

The current line phase and frame phase are exported for neighbouring logic. A single-clock flag marks the moment the frame enters vertical blanking. All configuration arrives on input ports. A shadow copy is taken during reset and again only at the last pixel of each frame, so a frame that is running always uses one consistent set of values. Every output is registered and reflects the scan position of the previous clock.

Top module: `panel_scan_timing`

## Requirements
- R1: A line lasts line_sync+line_begin+line_data+line_end pixel clocks. The pixel position p runs from 0 upward. line_phase is 0 (sync) while p < sync, 1 (begin) while p < sync+begin, 2 (data) while p < sync+begin+data, and 3 (end) otherwise. A phase of zero length never appears.
- R2: A frame lasts frame_sync+frame_begin+frame_data+frame_end+holdoff lines. The line index n starts at 0. frame_phase uses the same 0..3 codes, applied to n against the line counts. A phase of zero length never appears.
- R3: gate_clk has a period of exactly one line. It is high when (p − gclk_offset) mod L < gclk_high, where L is the line length and gclk_offset < L.
- R4: With start-pulse mode 0, the start pulse is active for one line time, beginning at pixel sp_offset (< L) of line n = frame_sync. It therefore spans line frame_sync from that pixel onward and line frame_sync+1 below that pixel.
- R5: With start-pulse mode 1, the start pulse is active on every line with n < frame_sync, and sp_offset has no effect.
- R6: With gate-enable mode 0, gate_oe is active on lines frame_sync ≤ n < frame_sync+frame_begin+frame_data+frame_end. It is never active during frame sync or hold-off.
- R7: With gate-enable mode 1, gate_oe is a copy of gate_clk delayed by oe_delay pixel clocks, so it is high when (p − gclk_offset − oe_delay) mod L < gclk_high, with gclk_offset+oe_delay < 2L. It is active only on frame-data lines.
- R8: The latch enable is active while p < line_sync, so it falls at the end of line sync. The first source pulse is active for line_sync+soe1_delay ≤ p < line_sync+soe1_delay+soe1_width. Both windows are cut at the end of the line.
- R9: The second source pulse starts soe2_delay pixel clocks after the first pulse ends and stays active for soe2_width pixel clocks, also cut at the end of the line.
- R10: Each of gate_start, gate_oe, src_le, src_oe1 and src_oe2 has its own polarity bit. A bit of 1 means active-high, and a bit of 0 means the signal is low when active and high when idle.
- R11: The hold-off lines follow the frame-end lines. They are reported as frame phase 3, and they delay the next frame sync by that many lines.
- R12: frame_done is high for exactly one clock, at pixel 0 of the first blanking line (n = frame_sync+frame_begin+frame_data). It never rises when frame_end+holdoff is 0.
- R13: A configuration change on the inputs takes effect only from pixel 0 of line 0 of the next frame. The rest of the current frame keeps the old values.
- R14: While reset is high for at least two clocks, both phases read 0, frame_done and gate_clk are 0, and each polarised output sits at its idle level. After reset falls, each output reflects the scan position one clock earlier, starting from pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_line_sync | input | HW | Line sync length in pixel clocks |
| cfg_line_begin | input | HW | Line begin length in pixel clocks |
| cfg_line_data | input | HW | Line data length in pixel clocks |
| cfg_line_end | input | HW | Line end length in pixel clocks |
| cfg_frame_sync | input | FW | Frame sync length in lines |
| cfg_frame_begin | input | FW | Frame begin length in lines |
| cfg_frame_data | input | VW | Frame data length in lines |
| cfg_frame_end | input | FW | Frame end length in lines |
| cfg_holdoff | input | HOLD_W | Extra blanking lines after frame end |
| cfg_gclk_high | input | HW | Gate clock high width in pixel clocks |
| cfg_gclk_offset | input | HW | Gate clock offset from line start |
| cfg_sp_mode | input | 1 | Start-pulse mode (0 one line, 1 whole sync) |
| cfg_sp_offset | input | HW | Start-pulse offset in pixel clocks, mode 0 |
| cfg_oe_mode | input | 1 | Gate-enable mode (0 scan window, 1 delayed clock) |
| cfg_oe_delay | input | HW | Gate-enable delay after the gate clock, mode 1 |
| cfg_soe1_delay | input | SW | First source pulse delay after latch fall |
| cfg_soe1_width | input | SW | First source pulse width |
| cfg_soe2_delay | input | SW | Second source pulse delay after first pulse ends |
| cfg_soe2_width | input | SW | Second source pulse width |
| cfg_sp_pol | input | 1 | Start-pulse polarity (1 active-high) |
| cfg_oe_pol | input | 1 | Gate-enable polarity |
| cfg_le_pol | input | 1 | Latch-enable polarity |
| cfg_soe1_pol | input | 1 | First source pulse polarity |
| cfg_soe2_pol | input | 1 | Second source pulse polarity |
| gate_clk | output | 1 | Gate-driver clock |
| gate_start | output | 1 | Gate-driver start pulse |
| gate_oe | output | 1 | Gate-driver output enable |
| src_le | output | 1 | Source latch enable |
| src_oe1 | output | 1 | First source output-enable pulse |
| src_oe2 | output | 1 | Second source output-enable pulse |
| line_phase | output | 2 | Current line phase code |
| frame_phase | output | 2 | Current frame phase code |
| frame_done | output | 1 | One-clock flag on entry to blanking |

## Verification
All outputs are pure functions of the pixel and line position and the shadowed settings. A wrong count, a missed wrap or a stale shadow value therefore shows on the very next registered output. It appears first on line_phase, src_le or gate_clk within one line, and on frame_phase or gate_start within one frame. The bench runs several complete frames of three small settings. Between them it covers zero-length phases, both modes of each gate signal, both polarities and hold-off-only blanking. It changes the settings in mid-frame to expose early loading, and it compares every output on every clock against positions computed arithmetically.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BEGIN = 2'd1,
    PH_DATA  = 2'd2,
    PH_END   = 2'd3
  } scan_phase_e;
endpackage

// File: rtl/scan_cfg_hold.sv
module scan_cfg_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Shadow copy: refreshed during reset and on the final pixel of a frame.
  always_ff @(posedge clk) begin
    if (rst || load) q <= d;
  end

  // R13: between frame boundaries the shadow must not move
  a_r13_shadow_steady: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && !$past(rst)) |-> $stable(q));
endmodule

// File: rtl/scan_timebase.sv
module scan_timebase #(
  parameter int LW  = 14,
  parameter int FLW = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LW-1:0]  line_len,
  input  logic [FLW-1:0] frame_len,
  output logic [LW-1:0]  px,
  output logic [FLW-1:0] ln,
  output logic           line_last,
  output logic           frame_last
);
  // A zero length behaves as one, so the counters can never stall.
  assign line_last  = (px + LW'(1)) >= line_len;
  assign frame_last = line_last && ((ln + FLW'(1)) >= frame_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      px <= '0;
      ln <= '0;
    end else if (line_last) begin
      px <= '0;
      ln <= frame_last ? '0 : ln + FLW'(1);
    end else begin
      px <= px + LW'(1);
    end
  end

  a_r1_px_limit: assert property (@(posedge clk) disable iff (rst)
    (px < line_len) || (px == '0));
  a_r2_ln_limit: assert property (@(posedge clk) disable iff (rst)
    (ln < frame_len) || (ln == '0));
  a_r1_line_restart: assert property (@(posedge clk) disable iff (rst)
    line_last |=> (px == '0));
endmodule

// File: rtl/scan_phase_dec.sv
module scan_phase_dec
  import scan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] b1,
  input  logic [W-1:0] b2,
  input  logic [W-1:0] b3,
  output scan_phase_e  phase
);
  // Boundaries are cumulative, so an empty phase has no positions.
  always_comb begin
    if (pos < b1)      phase = PH_SYNC;
    else if (pos < b2) phase = PH_BEGIN;
    else if (pos < b3) phase = PH_DATA;
    else               phase = PH_END;
  end
endmodule

// File: rtl/scan_gate.sv
module scan_gate #(
  parameter int HW  = 12,
  parameter int LW  = 14,
  parameter int FLW = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LW-1:0]  px,
  input  logic [LW-1:0]  line_len,
  input  logic [FLW-1:0] ln,
  input  logic [FLW-1:0] f1,
  input  logic [FLW-1:0] f2,
  input  logic [FLW-1:0] f3,
  input  logic [FLW-1:0] f4,
  input  logic [HW-1:0]  gclk_high,
  input  logic [HW-1:0]  gclk_offset,
  input  logic           sp_mode,
  input  logic [HW-1:0]  sp_offset,
  input  logic           oe_mode,
  input  logic [HW-1:0]  oe_delay,
  input  logic           sp_pol,
  input  logic           oe_pol,
  output logic           gate_clk,
  output logic           gate_start,
  output logic           gate_oe
);
  // Distance of px past a shift point, wrapped into one line.
  function automatic logic [LW-1:0] rel_pos(input logic [LW-1:0] x,
                                            input logic [LW-1:0] s,
                                            input logic [LW-1:0] len);
    rel_pos = (x >= s) ? (x - s) : (x + len - s);
  endfunction

  logic [LW-1:0] goff_x, high_x, spoff_x, oe_shift, clk_ph, oe_ph;
  logic [LW:0]   shift_sum;
  logic          clk_c, oe_pulse, sp_c, oe_c;

  assign goff_x  = LW'(gclk_offset);
  assign high_x  = LW'(gclk_high);
  assign spoff_x = LW'(sp_offset);
  assign shift_sum = {1'b0, goff_x} + (LW+1)'(oe_delay);
  assign oe_shift  = (shift_sum >= {1'b0, line_len}) ? LW'(shift_sum - {1'b0, line_len})
                                                      : LW'(shift_sum);
  assign clk_ph   = rel_pos(px, goff_x, line_len);
  assign oe_ph    = rel_pos(px, oe_shift, line_len);
  assign clk_c    = clk_ph < high_x;
  assign oe_pulse = oe_ph < high_x;

  always_comb begin
    if (sp_mode) sp_c = ln < f1;
    else         sp_c = ((ln == f1) && (px >= spoff_x)) ||
                        ((ln == f1 + FLW'(1)) && (px < spoff_x));
    if (oe_mode) oe_c = (ln >= f2) && (ln < f3) && oe_pulse;
    else         oe_c = (ln >= f1) && (ln < f4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_clk   <= 1'b0;
      gate_start <= ~sp_pol;
      gate_oe    <= ~oe_pol;
    end else begin
      gate_clk   <= clk_c;
      gate_start <= ~(sp_c ^ sp_pol);
      gate_oe    <= ~(oe_c ^ oe_pol);
    end
  end
endmodule

// File: rtl/scan_src.sv
module scan_src #(
  parameter int HW = 12,
  parameter int LW = 14,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] px,
  input  logic [HW-1:0] line_sync,
  input  logic [SW-1:0] soe1_delay,
  input  logic [SW-1:0] soe1_width,
  input  logic [SW-1:0] soe2_delay,
  input  logic [SW-1:0] soe2_width,
  input  logic          le_pol,
  input  logic          soe1_pol,
  input  logic          soe2_pol,
  output logic          src_le,
  output logic          src_oe1,
  output logic          src_oe2
);
  localparam int PW = LW + 1;

  logic [PW-1:0] pos, s1, e1, s2, e2;
  logic          le_c, a1_c, a2_c;

  // Pulse edges chain off the latch-enable fall at the end of line sync.
  assign pos = PW'(px);
  assign s1  = PW'(line_sync) + PW'(soe1_delay);
  assign e1  = s1 + PW'(soe1_width);
  assign s2  = e1 + PW'(soe2_delay);
  assign e2  = s2 + PW'(soe2_width);

  assign le_c = pos < PW'(line_sync);
  assign a1_c = (pos >= s1) && (pos < e1);
  assign a2_c = (pos >= s2) && (pos < e2);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_le  <= ~le_pol;
      src_oe1 <= ~soe1_pol;
      src_oe2 <= ~soe2_pol;
    end else begin
      src_le  <= ~(le_c ^ le_pol);
      src_oe1 <= ~(a1_c ^ soe1_pol);
      src_oe2 <= ~(a2_c ^ soe2_pol);
    end
  end

  // R8: the first pulse never overlaps the latch enable
  a_r8_le_before_oe1: assert property (@(posedge clk) disable iff (rst)
    (src_le == $past(le_pol)) |-> (src_oe1 != $past(soe1_pol)));
  // R9: the second pulse never overlaps the first
  a_r9_oe_pulses_apart: assert property (@(posedge clk) disable iff (rst)
    (src_oe1 == $past(soe1_pol)) |-> (src_oe2 != $past(soe2_pol)));
endmodule

// File: rtl/panel_scan_timing.sv
module panel_scan_timing
  import scan_pkg::*;
#(
  parameter int HW     = 12,
  parameter int FW     = 8,
  parameter int VW     = 11,
  parameter int HOLD_W = 9,
  parameter int SW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HW-1:0]     cfg_line_sync,
  input  logic [HW-1:0]     cfg_line_begin,
  input  logic [HW-1:0]     cfg_line_data,
  input  logic [HW-1:0]     cfg_line_end,
  input  logic [FW-1:0]     cfg_frame_sync,
  input  logic [FW-1:0]     cfg_frame_begin,
  input  logic [VW-1:0]     cfg_frame_data,
  input  logic [FW-1:0]     cfg_frame_end,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  input  logic [HW-1:0]     cfg_gclk_high,
  input  logic [HW-1:0]     cfg_gclk_offset,
  input  logic              cfg_sp_mode,
  input  logic [HW-1:0]     cfg_sp_offset,
  input  logic              cfg_oe_mode,
  input  logic [HW-1:0]     cfg_oe_delay,
  input  logic [SW-1:0]     cfg_soe1_delay,
  input  logic [SW-1:0]     cfg_soe1_width,
  input  logic [SW-1:0]     cfg_soe2_delay,
  input  logic [SW-1:0]     cfg_soe2_width,
  input  logic              cfg_sp_pol,
  input  logic              cfg_oe_pol,
  input  logic              cfg_le_pol,
  input  logic              cfg_soe1_pol,
  input  logic              cfg_soe2_pol,
  output logic              gate_clk,
  output logic              gate_start,
  output logic              gate_oe,
  output logic              src_le,
  output logic              src_oe1,
  output logic              src_oe2,
  output logic [1:0]        line_phase,
  output logic [1:0]        frame_phase,
  output logic              frame_done
);
  localparam int LW   = HW + 2;
  localparam int MX1  = (VW > FW) ? VW : FW;
  localparam int MX2  = (MX1 > HOLD_W) ? MX1 : HOLD_W;
  localparam int FLW  = MX2 + 3;
  localparam int CFGW = 8*HW + 3*FW + VW + HOLD_W + 4*SW + 7;

  logic [CFGW-1:0] cfg_d, cfg_q;

  logic [HW-1:0]     s_line_sync, s_line_begin, s_line_data, s_line_end;
  logic [FW-1:0]     s_frame_sync, s_frame_begin, s_frame_end;
  logic [VW-1:0]     s_frame_data;
  logic [HOLD_W-1:0] s_holdoff;
  logic [HW-1:0]     s_gclk_high, s_gclk_offset, s_sp_offset, s_oe_delay;
  logic              s_sp_mode, s_oe_mode;
  logic [SW-1:0]     s_soe1_delay, s_soe1_width, s_soe2_delay, s_soe2_width;
  logic              s_sp_pol, s_oe_pol, s_le_pol, s_soe1_pol, s_soe2_pol;

  assign cfg_d = {cfg_line_sync, cfg_line_begin, cfg_line_data, cfg_line_end,
                  cfg_frame_sync, cfg_frame_begin, cfg_frame_data, cfg_frame_end,
                  cfg_holdoff, cfg_gclk_high, cfg_gclk_offset, cfg_sp_mode,
                  cfg_sp_offset, cfg_oe_mode, cfg_oe_delay, cfg_soe1_delay,
                  cfg_soe1_width, cfg_soe2_delay, cfg_soe2_width, cfg_sp_pol,
                  cfg_oe_pol, cfg_le_pol, cfg_soe1_pol, cfg_soe2_pol};

  assign {s_line_sync, s_line_begin, s_line_data, s_line_end,
          s_frame_sync, s_frame_begin, s_frame_data, s_frame_end,
          s_holdoff, s_gclk_high, s_gclk_offset, s_sp_mode,
          s_sp_offset, s_oe_mode, s_oe_delay, s_soe1_delay,
          s_soe1_width, s_soe2_delay, s_soe2_width, s_sp_pol,
          s_oe_pol, s_le_pol, s_soe1_pol, s_soe2_pol} = cfg_q;

  logic           line_last, frame_last;
  logic [LW-1:0]  px;
  logic [FLW-1:0] ln;

  scan_cfg_hold #(.W(CFGW)) u_hold (
    .clk (clk), .rst (rst), .load (frame_last), .d (cfg_d), .q (cfg_q)
  );

  // Cumulative phase boundaries within a line and within a frame.
  logic [LW-1:0]  hb1, hb2, hb3, line_len;
  logic [FLW-1:0] vb1, vb2, vb3, vb4, frame_len;

  assign hb1      = LW'(s_line_sync);
  assign hb2      = hb1 + LW'(s_line_begin);
  assign hb3      = hb2 + LW'(s_line_data);
  assign line_len = hb3 + LW'(s_line_end);

  assign vb1       = FLW'(s_frame_sync);
  assign vb2       = vb1 + FLW'(s_frame_begin);
  assign vb3       = vb2 + FLW'(s_frame_data);
  assign vb4       = vb3 + FLW'(s_frame_end);
  assign frame_len = vb4 + FLW'(s_holdoff);

  scan_timebase #(.LW(LW), .FLW(FLW)) u_tb (
    .clk (clk), .rst (rst), .line_len (line_len), .frame_len (frame_len),
    .px (px), .ln (ln), .line_last (line_last), .frame_last (frame_last)
  );

  scan_phase_e lph_c, fph_c, lph_q, fph_q;

  scan_phase_dec #(.W(LW)) u_hdec (
    .pos (px), .b1 (hb1), .b2 (hb2), .b3 (hb3), .phase (lph_c)
  );
  scan_phase_dec #(.W(FLW)) u_vdec (
    .pos (ln), .b1 (vb1), .b2 (vb2), .b3 (vb3), .phase (fph_c)
  );

  scan_gate #(.HW(HW), .LW(LW), .FLW(FLW)) u_gate (
    .clk (clk), .rst (rst), .px (px), .line_len (line_len), .ln (ln),
    .f1 (vb1), .f2 (vb2), .f3 (vb3), .f4 (vb4),
    .gclk_high (s_gclk_high), .gclk_offset (s_gclk_offset),
    .sp_mode (s_sp_mode), .sp_offset (s_sp_offset),
    .oe_mode (s_oe_mode), .oe_delay (s_oe_delay),
    .sp_pol (s_sp_pol), .oe_pol (s_oe_pol),
    .gate_clk (gate_clk), .gate_start (gate_start), .gate_oe (gate_oe)
  );

  scan_src #(.HW(HW), .LW(LW), .SW(SW)) u_src (
    .clk (clk), .rst (rst), .px (px), .line_sync (s_line_sync),
    .soe1_delay (s_soe1_delay), .soe1_width (s_soe1_width),
    .soe2_delay (s_soe2_delay), .soe2_width (s_soe2_width),
    .le_pol (s_le_pol), .soe1_pol (s_soe1_pol), .soe2_pol (s_soe2_pol),
    .src_le (src_le), .src_oe1 (src_oe1), .src_oe2 (src_oe2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lph_q      <= PH_SYNC;
      fph_q      <= PH_SYNC;
      frame_done <= 1'b0;
    end else begin
      lph_q      <= lph_c;
      fph_q      <= fph_c;
      frame_done <= (px == '0) && (ln == vb3) && (vb3 < frame_len);
    end
  end

  assign line_phase  = lph_q;
  assign frame_phase = fph_q;

  // R12: the blanking flag only appears inside the blanking phase
  a_r12_done_in_blank: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (fph_q == PH_END));
  // R5: in whole-sync mode an active start pulse implies frame sync
  a_r5_sp_in_sync: assert property (@(posedge clk) disable iff (rst)
    ($past(s_sp_mode) && (gate_start == $past(s_sp_pol))) |-> (fph_q == PH_SYNC));
  // R6: in scan-window mode the gate enable is idle during frame sync
  a_r6_oe_off_in_sync: assert property (@(posedge clk) disable iff (rst)
    (!$past(s_oe_mode) && (fph_q == PH_SYNC)) |-> (gate_oe != $past(s_oe_pol)));
  // R7: in delayed-clock mode the gate enable is confined to data lines
  a_r7_oe_in_data: assert property (@(posedge clk) disable iff (rst)
    ($past(s_oe_mode) && (gate_oe == $past(s_oe_pol))) |-> (fph_q == PH_DATA));
endmodule

// File: tb/sim_panel_scan_timing.sv
`timescale 1ns/1ps
module sim_panel_scan_timing;
  typedef struct {
    int ls, lb, ld, le;
    int fs, fb, fd, fe, ho;
    int gh, goff, spm, spoff, oem, gdel;
    int d1, w1, d2, w2;
    int psp, poe, ple, p1, p2;
  } cfg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  cfg_t cfg, mcfg;
  int   mpx, mln;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  string tag13 = "";

  logic gate_clk, gate_start, gate_oe, src_le, src_oe1, src_oe2, frame_done;
  logic [1:0] line_phase, frame_phase;

  always #10 clk = ~clk;

  panel_scan_timing u0 (
    .clk (clk), .rst (rst),
    .cfg_line_sync (cfg.ls[11:0]), .cfg_line_begin (cfg.lb[11:0]),
    .cfg_line_data (cfg.ld[11:0]), .cfg_line_end (cfg.le[11:0]),
    .cfg_frame_sync (cfg.fs[7:0]), .cfg_frame_begin (cfg.fb[7:0]),
    .cfg_frame_data (cfg.fd[10:0]), .cfg_frame_end (cfg.fe[7:0]),
    .cfg_holdoff (cfg.ho[8:0]),
    .cfg_gclk_high (cfg.gh[11:0]), .cfg_gclk_offset (cfg.goff[11:0]),
    .cfg_sp_mode (cfg.spm[0]), .cfg_sp_offset (cfg.spoff[11:0]),
    .cfg_oe_mode (cfg.oem[0]), .cfg_oe_delay (cfg.gdel[11:0]),
    .cfg_soe1_delay (cfg.d1[7:0]), .cfg_soe1_width (cfg.w1[7:0]),
    .cfg_soe2_delay (cfg.d2[7:0]), .cfg_soe2_width (cfg.w2[7:0]),
    .cfg_sp_pol (cfg.psp[0]), .cfg_oe_pol (cfg.poe[0]), .cfg_le_pol (cfg.ple[0]),
    .cfg_soe1_pol (cfg.p1[0]), .cfg_soe2_pol (cfg.p2[0]),
    .gate_clk (gate_clk), .gate_start (gate_start), .gate_oe (gate_oe),
    .src_le (src_le), .src_oe1 (src_oe1), .src_oe2 (src_oe2),
    .line_phase (line_phase), .frame_phase (frame_phase), .frame_done (frame_done)
  );

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s ln=%0d px=%0d: actual %0d expected %0d", req, nm, mln, mpx, act, exp);
    end
  endtask

  function automatic int lvl(input int act, input int pol);
    return pol != 0 ? act : (act != 0 ? 0 : 1);
  endfunction

  // Compare every output with the arithmetic expectation for (mln, mpx) under mcfg.
  task automatic compare();
    int L, F, E, F4, sh2, lph, fph, sp, oe, le, a1, a2, gc, fdn, s1, s2;
    cfg_t c;
    c   = mcfg;
    L   = c.ls + c.lb + c.ld + c.le;
    E   = c.fs + c.fb + c.fd;
    F4  = E + c.fe;
    F   = F4 + c.ho;
    lph = (mpx < c.ls) ? 0 : (mpx < c.ls + c.lb) ? 1 : (mpx < c.ls + c.lb + c.ld) ? 2 : 3;
    fph = (mln < c.fs) ? 0 : (mln < c.fs + c.fb) ? 1 : (mln < E) ? 2 : 3;
    gc  = (((mpx - c.goff + L) % L) < c.gh) ? 1 : 0;
    sh2 = (c.goff + c.gdel) % L;
    if (c.spm != 0) sp = (mln < c.fs) ? 1 : 0;
    else sp = (((mln == c.fs) && (mpx >= c.spoff)) || ((mln == c.fs + 1) && (mpx < c.spoff))) ? 1 : 0;
    if (c.oem != 0) oe = ((mln >= c.fs + c.fb) && (mln < E) && (((mpx - sh2 + L) % L) < c.gh)) ? 1 : 0;
    else oe = ((mln >= c.fs) && (mln < F4)) ? 1 : 0;
    s1  = c.ls + c.d1;
    s2  = s1 + c.w1 + c.d2;
    le  = (mpx < c.ls) ? 1 : 0;
    a1  = ((mpx >= s1) && (mpx < s1 + c.w1)) ? 1 : 0;
    a2  = ((mpx >= s2) && (mpx < s2 + c.w2)) ? 1 : 0;
    fdn = ((mpx == 0) && (mln == E) && (E < F)) ? 1 : 0;
    chk({tag13, "R1"}, "line_phase", int'(line_phase), lph);
    chk({tag13, (mln >= F4) ? "R11" : "R2"}, "frame_phase", int'(frame_phase), fph);
    chk({tag13, "R3"}, "gate_clk", int'(gate_clk), gc);
    chk({tag13, (c.spm != 0) ? "R5/R10" : "R4/R10"}, "gate_start", int'(gate_start), lvl(sp, c.psp));
    chk({tag13, (c.oem != 0) ? "R7/R10" : "R6/R10"}, "gate_oe", int'(gate_oe), lvl(oe, c.poe));
    chk({tag13, "R8/R10"}, "src_le", int'(src_le), lvl(le, c.ple));
    chk({tag13, "R8/R10"}, "src_oe1", int'(src_oe1), lvl(a1, c.p1));
    chk({tag13, "R9/R10"}, "src_oe2", int'(src_oe2), lvl(a2, c.p2));
    chk({tag13, "R12"}, "frame_done", int'(frame_done), fdn);
  endtask

  // One clock: outputs after the edge reflect the position held before it.
  task automatic step();
    int L, F;
    @(posedge clk);
    @(negedge clk);
    compare();
    L = mcfg.ls + mcfg.lb + mcfg.ld + mcfg.le;
    F = mcfg.fs + mcfg.fb + mcfg.fd + mcfg.fe + mcfg.ho;
    if (mpx + 1 >= L) begin
      mpx = 0;
      if (mln + 1 >= F) begin
        mln   = 0;
        mcfg  = cfg;
        tag13 = "";
      end else mln++;
    end else mpx++;
  endtask

  initial begin
    cfg_t ca, cb, cc;
    ca = '{ls:2, lb:1, ld:4, le:1, fs:1, fb:1, fd:3, fe:1, ho:1,
           gh:3, goff:6, spm:0, spoff:5, oem:1, gdel:4,
           d1:1, w1:2, d2:1, w2:2, psp:1, poe:0, ple:1, p1:1, p2:0};
    cb = '{ls:1, lb:0, ld:3, le:0, fs:2, fb:0, fd:2, fe:0, ho:0,
           gh:2, goff:0, spm:1, spoff:0, oem:0, gdel:0,
           d1:0, w1:1, d2:0, w2:5, psp:0, poe:1, ple:0, p1:0, p2:1};
    cc = '{ls:0, lb:2, ld:2, le:2, fs:0, fb:2, fd:2, fe:0, ho:3,
           gh:1, goff:5, spm:0, spoff:0, oem:1, gdel:0,
           d1:0, w1:0, d2:2, w2:1, psp:1, poe:1, ple:1, p1:1, p2:1};
    cfg = ca;
    mcfg = ca;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R14: reset state, idle levels per polarity (R10)
    chk("R14", "line_phase", int'(line_phase), 0);
    chk("R14", "frame_phase", int'(frame_phase), 0);
    chk("R14", "frame_done", int'(frame_done), 0);
    chk("R14", "gate_clk", int'(gate_clk), 0);
    chk("R14/R10", "gate_start", int'(gate_start), 0);
    chk("R14/R10", "gate_oe", int'(gate_oe), 1);
    chk("R14/R10", "src_le", int'(src_le), 0);
    chk("R14/R10", "src_oe1", int'(src_oe1), 0);
    chk("R14/R10", "src_oe2", int'(src_oe2), 1);
    rst = 1'b0;
    mpx = 0;
    mln = 0;
    mcfg = cfg;
    // Two full frames of A, then switch in mid-frame (R13).
    repeat (130) step();
    cfg = cb;
    tag13 = "R13/";
    repeat (90) step();
    cfg = cc;
    tag13 = "R13/";
    repeat (160) step();
    cfg = ca;
    tag13 = "R13/";
    repeat (120) step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL R14 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule